// File: doc/BRIEF.md
# Instruction Fetch Execution Monitor

This block sits between a CPU and its RAM read path and blocks code execution from chosen memory areas. On every CPU access it looks at the address and at whether the access is an instruction fetch. When a fetch falls inside a protected area, the block returns a word of all zeros instead of the memory contents. The CPU decodes that word as an illegal instruction and traps.

There are two protected areas. The first is fixed by parameters and covers firmware RAM. It is protected at all times. The second is set up by software: it writes the lower and upper bound registers and then writes the control register to arm protection. Arming cannot be undone before reset, and once armed the bounds are frozen. Data reads are never altered, in either area.

The block also watches the CPU trap signal. After a trap it drives a red blink on the RGB LED outputs, with a parameterised period and a 50% duty cycle, and ignores the LED value that software set. The blink continues until reset. The fetch path is purely combinational and has no handshake: it qualifies each access with `cpu_valid` and never stalls, so it adds no back-pressure to the memory path. The register port and the LED pins are plain control signals.

Top module: `exmon_top`

## Requirements
- R1: After reset the arm flag and both bound registers read as zero, and `led_out` equals `led_reg`.
- R2: Any write to word 0x60 arms the monitor, whatever the write data. Bit 0 of a read from 0x60 returns the arm flag. Later writes, including writes of zero, never disarm it before reset.
- R3: While the monitor is not armed, a write to word 0x61 sets the lower bound and a write to word 0x62 sets the upper bound. Both read back at the same addresses.
- R4: Once the monitor is armed, writes to 0x61 and 0x62 are ignored. The bounds read back unchanged, and the protected area does not move.
- R5: While armed, an instruction fetch whose address lies in [lower, upper], both ends included, returns zero on `cpu_rdata`. Addresses just outside either bound return `mem_rdata`.
- R6: While not armed, instruction fetches in the software area return `mem_rdata`.
- R7: Accesses with `cpu_instr` low return `mem_rdata` in every area.
- R8: An instruction fetch in the fixed area [FW_LO, FW_HI], both ends included, returns zero whether or not the monitor is armed.
- R9: A clock edge that samples `cpu_trap` high latches a trapped state until reset. From that edge, with the count k starting at 0, `led_out[2]` (red) is 1 when (k mod FLASH_PERIOD) < FLASH_PERIOD/2 and 0 otherwise. `led_out[1:0]` (green, blue) are 0, and `led_reg` is ignored.
- R10: While not trapped, `led_out` equals `led_reg` in the same cycle.
- R11: A read of any register word other than 0x60 to 0x62 returns zero. Read data appears on `reg_rdata` after the clock edge that samples the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_cs | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| cpu_valid | input | 1 | CPU access in progress |
| cpu_instr | input | 1 | Access is an instruction fetch |
| cpu_addr | input | 32 | CPU byte address |
| mem_rdata | input | 32 | Data returned by RAM |
| cpu_rdata | output | 32 | Data returned to CPU after substitution |
| cpu_trap | input | 1 | CPU trap indication |
| led_reg | input | 3 | Software LED value {red, green, blue} |
| led_out | output | 3 | LED drive {red, green, blue} |

## Verification
The hardest case to reach is the frozen-bounds behaviour. It only exists after the one-way arm write, so the bench programs and checks the area while disarmed first. It then arms the monitor and tries to move a bound, and proves through both readback and fetch results that the protected area has not moved. The trap blink is also one-way, so it runs last and is sampled for two full periods, edge by edge, from the cycle that latches the trap.

// File: rtl/exmon_pkg.sv
package exmon_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int RADDR_W = 8;
  localparam int LED_W = 3;
  localparam int LED_RED = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  localparam logic [RADDR_W-1:0] REG_ARM   = 8'h60;
  localparam logic [RADDR_W-1:0] REG_LOWER = 8'h61;
  localparam logic [RADDR_W-1:0] REG_UPPER = 8'h62;
endpackage

// File: rtl/exmon_regs.sv
module exmon_regs
  import exmon_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_cs,
  input  logic               reg_we,
  input  logic [RADDR_W-1:0] reg_addr,
  input  word_t              reg_wdata,
  output word_t              reg_rdata,
  output logic               armed,
  output addr_t              lower,
  output addr_t              upper
);
  logic wr, rd;
  assign wr = reg_cs & reg_we;
  assign rd = reg_cs & ~reg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      lower <= '0;
      upper <= '0;
    end else if (wr) begin
      unique case (reg_addr)
        REG_ARM:   armed <= 1'b1;
        REG_LOWER: if (!armed) lower <= addr_t'(reg_wdata);
        REG_UPPER: if (!armed) upper <= addr_t'(reg_wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (rd) begin
      unique case (reg_addr)
        REG_ARM:   reg_rdata <= word_t'(armed);
        REG_LOWER: reg_rdata <= word_t'(lower);
        REG_UPPER: reg_rdata <= word_t'(upper);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  // R2: arming is one-way
  a_r2_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  // R4: bounds frozen while armed
  a_r4_bounds_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($stable(lower) && $stable(upper)));
endmodule

// File: rtl/exmon_window.sv
module exmon_window
  import exmon_pkg::*;
(
  input  logic  active,
  input  addr_t addr,
  input  addr_t lo,
  input  addr_t hi,
  output logic  hit
);
  assign hit = active && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/exmon_flash.sv
module exmon_flash #(
  parameter int PERIOD = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_in,
  output logic trapped,
  output logic red_on
);
  localparam int HALF = PERIOD / 2;
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trapped <= 1'b0;
      cnt     <= '0;
    end else begin
      if (trap_in) trapped <= 1'b1;
      if (trapped) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign red_on = trapped && (cnt < HALF_C);

  // R9: trap state latches
  a_r9_trap_latched: assert property (@(posedge clk) disable iff (!rst_n)
    trapped |=> trapped);
  // R9: counter wraps at the end of the period
  a_r9_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (trapped && cnt == LAST) |=> (cnt == '0));
endmodule

// File: rtl/exmon_top.sv
module exmon_top
  import exmon_pkg::*;
#(
  parameter logic [31:0] FW_LO = 32'h0000_F000,
  parameter logic [31:0] FW_HI = 32'h0000_F0FF,
  parameter int FLASH_PERIOD = 12_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_cs,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cpu_valid,
  input  logic        cpu_instr,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] mem_rdata,
  output logic [31:0] cpu_rdata,
  input  logic        cpu_trap,
  input  logic [2:0]  led_reg,
  output logic [2:0]  led_out
);
  localparam int NWIN = 2;

  logic  armed, trapped, red_on;
  addr_t lower, upper;
  logic  [NWIN-1:0] win_act, win_hit;
  addr_t win_lo [NWIN];
  addr_t win_hi [NWIN];
  logic  fetch, blocked;

  exmon_regs u_regs (
    .clk, .rst_n, .reg_cs, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .armed, .lower, .upper
  );

  // window 0: fixed firmware area, window 1: software area
  assign win_act[0] = 1'b1;
  assign win_lo[0]  = FW_LO;
  assign win_hi[0]  = FW_HI;
  assign win_act[1] = armed;
  assign win_lo[1]  = lower;
  assign win_hi[1]  = upper;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    exmon_window u_win (
      .active(win_act[g]), .addr(cpu_addr),
      .lo(win_lo[g]), .hi(win_hi[g]), .hit(win_hit[g])
    );
  end

  assign fetch     = cpu_valid && cpu_instr;
  assign blocked   = fetch && (|win_hit);
  assign cpu_rdata = blocked ? '0 : mem_rdata;

  exmon_flash #(.PERIOD(FLASH_PERIOD)) u_flash (
    .clk, .rst_n, .trap_in(cpu_trap), .trapped, .red_on
  );

  always_comb begin
    if (trapped) begin
      led_out = '0;
      led_out[LED_RED] = red_on;
    end else begin
      led_out = led_reg;
    end
  end

  // R8: fixed area always blocks fetches
  a_r8_fw_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && win_hit[0]) |-> (cpu_rdata == '0));
  // R5: armed software area blocks fetches
  a_r5_user_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && armed && cpu_addr >= lower && cpu_addr <= upper) |-> (cpu_rdata == '0));
  // R7: data reads untouched
  a_r7_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_instr) |-> (cpu_rdata == mem_rdata));
  // R10: LED follows software when not trapped
  a_r10_led_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !trapped |-> (led_out == led_reg));
endmodule

// File: tb/exmon_top_bench.sv
module exmon_top_bench;
  localparam int P = 8;
  localparam int H = P / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_cs = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        cpu_valid = 1'b0, cpu_instr = 1'b0;
  logic [31:0] cpu_addr = '0, mem_rdata = '0, cpu_rdata;
  logic        cpu_trap = 1'b0;
  logic [2:0]  led_reg = 3'b101, led_out;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  exmon_top #(.FLASH_PERIOD(P)) u_exmon_top (.*);

  always #4 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_cs = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_cs = 1'b0;
    check(tag, reg_rdata, exp);
  endtask

  // driver: pushes the expected return word, monitor compares it
  task automatic fetch(logic [31:0] a, logic instr, logic [31:0] d, logic zero, string tag);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_instr = instr; cpu_addr = a; mem_rdata = d;
    exp_q.push_back(zero ? 32'h0 : d);
    tag_q.push_back(tag);
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    #2;
    if (cpu_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard empty actual=%h expected=none", cpu_rdata);
      end else begin
        check(tag_q.pop_front(), cpu_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 check("R1 led pass", {29'd0, led_out}, 32'h5);
    reg_read(8'h60, 32'h0, "R1 arm");
    reg_read(8'h61, 32'h0, "R1 lower");
    reg_read(8'h62, 32'h0, "R1 upper");
    // R11 unused word
    reg_read(8'h63, 32'h0, "R11 unused");
    // R3 bounds while disarmed
    reg_write(8'h61, 32'h100);
    reg_write(8'h62, 32'h1FF);
    reg_read(8'h61, 32'h100, "R3 lower");
    reg_read(8'h62, 32'h1FF, "R3 upper");
    // R6 disarmed area open
    fetch(32'h150, 1'b1, 32'hDEAD_BEEF, 1'b0, "R6 disarmed fetch");
    // R8 fixed area always closed
    fetch(32'hF000, 1'b1, 32'h1234_5678, 1'b1, "R8 fw low");
    fetch(32'hF0FF, 1'b1, 32'h1234_5678, 1'b1, "R8 fw high");
    fetch(32'hF100, 1'b1, 32'h1234_5678, 1'b0, "R8 fw above");
    fetch(32'hF010, 1'b0, 32'hAAAA_5555, 1'b0, "R7 fw data read");
    // R2 arm with zero data
    reg_write(8'h60, 32'h0);
    reg_read(8'h60, 32'h1, "R2 armed");
    // R5 inclusive bounds
    fetch(32'h100, 1'b1, 32'hCAFE_0001, 1'b1, "R5 at lower");
    fetch(32'h1FF, 1'b1, 32'hCAFE_0002, 1'b1, "R5 at upper");
    fetch(32'h0FF, 1'b1, 32'hCAFE_0003, 1'b0, "R5 below");
    fetch(32'h200, 1'b1, 32'hCAFE_0004, 1'b0, "R5 above");
    // R7 data read inside
    fetch(32'h150, 1'b0, 32'hCAFE_0005, 1'b0, "R7 data inside");
    // R4 frozen bounds
    reg_write(8'h61, 32'h400);
    reg_write(8'h62, 32'h4FF);
    reg_read(8'h61, 32'h100, "R4 lower frozen");
    reg_read(8'h62, 32'h1FF, "R4 upper frozen");
    fetch(32'h400, 1'b1, 32'hCAFE_0006, 1'b0, "R4 area not moved");
    fetch(32'h180, 1'b1, 32'hCAFE_0007, 1'b1, "R4 old area kept");
    // R2 no disarm
    reg_write(8'h60, 32'h0);
    reg_read(8'h60, 32'h1, "R2 still armed");
    // R10 led follows
    @(negedge clk); led_reg = 3'b011;
    #1 check("R10 led follow", {29'd0, led_out}, 32'h3);
    // R9 trap blink
    @(negedge clk); cpu_trap = 1'b1; led_reg = 3'b111;
    @(negedge clk); cpu_trap = 1'b0;
    // this negedge follows edge k=0
    for (int k = 0; k < 2 * P; k++) begin
      check("R9 blink", {29'd0, led_out}, ((k % P) < H) ? 32'h4 : 32'h0);
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule